// File: doc/BRIEF.md
# Block-Granular SRAM Security Gate

This gate sits between a bus requester and a single 64 KB on-chip SRAM bank. The bank is cut into 256-byte blocks, and one configuration bit per block marks that block as secure or non-secure. Every incoming transfer is looked up against the bit of the block it addresses. A non-secure transfer that targets a secure block is never presented to the memory side. It is answered with an error instead, and a sticky violation flag is raised. That flag can drive an interrupt when the interrupt is enabled.

The per-block bits live in 32-bit attribute words, one word per group of 32 blocks (8 KB). Each group also has a lock bit that, once set, freezes its attribute word until reset. The gate's own configuration registers answer only secure accesses. A non-secure access to them changes nothing, reads back zero with an error, and is recorded in a second status flag.

Top module: `sram_sec_gate`

## Requirements
- R1: After reset every attribute word reads 0 (all blocks secure), the lock word reads 0, the control word reads 0, the status word reads 0 and `irq` is low.
- R2: For a transfer, the attribute word index is `reqAddr[15:13]` and the bit within it is `reqAddr[12:8]`. A bit value of 1 marks the block non-secure and 0 marks it secure.
- R3: A non-secure transfer to a secure block does not assert `memValid`. One cycle later `rspValid` and `rspErr` are high and `rspRdata` is zero. A blocked write leaves memory contents unchanged.
- R4: A secure transfer, or a non-secure transfer to a non-secure block, is forwarded with `memValid` in the same cycle. One cycle later it answers with `rspErr` low and `rspRdata` equal to the memory's read data.
- R5: Configuration offset 8 is the lock word (bit i locks attribute word i). A write ORs its data into the lock word, so lock bits can never be cleared before reset.
- R6: Configuration offsets 0 to 7 are the attribute words. A secure write to an unlocked word replaces it, and a write to a locked word is ignored.
- R7: A configuration access with `cfgSecure` low modifies no register, returns `cfgRdata` of zero with `cfgErr` high in the same cycle, and sets status bit 1.
- R8: A blocked transfer sets status bit 0 (offset 10). `irq` is high exactly when control bit 0 (offset 9) is 1 and any status bit is 1.
- R9: Writing to offset 11 clears each status bit whose data bit is 1. If a new event for a bit arrives in the same cycle as its clear, the bit stays set.
- R10: A transfer in the same cycle as a write to its block's attribute word is judged by the old attribute. The new value governs transfers from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Transfer request present |
| reqWrite | input | 1 | Transfer is a write |
| reqSecure | input | 1 | Transfer carries the secure attribute |
| reqAddr | input | 16 | Byte address within the bank |
| reqWdata | input | 32 | Write data |
| rspValid | output | 1 | Response for the transfer of the previous cycle |
| rspErr | output | 1 | Response is an error (transfer blocked) |
| rspRdata | output | 32 | Read data, zero when blocked |
| memValid | output | 1 | Request forwarded to the memory |
| memWrite | output | 1 | Forwarded write strobe |
| memAddr | output | 16 | Forwarded address |
| memWdata | output | 32 | Forwarded write data |
| memRdata | input | 32 | Memory read data, one cycle after request |
| cfgValid | input | 1 | Configuration access present |
| cfgWrite | input | 1 | Configuration access is a write |
| cfgSecure | input | 1 | Configuration access is secure |
| cfgAddr | input | 4 | Configuration word offset |
| cfgWdata | input | 32 | Configuration write data |
| cfgRdata | output | 32 | Configuration read data, same cycle |
| cfgErr | output | 1 | Configuration access refused |
| irq | output | 1 | Violation interrupt |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is a status clear and a fresh violation. The bench issues a clear write to offset 11 in the very cycle a blocked non-secure read arrives. It then reads the status word, which must still show bit 0 with `irq` high, and only a later lone clear may drop it. The second pair is an attribute write and a transfer to the block being rewritten. A non-secure read is launched alongside the write that opens its block. The scoreboard expects that read to be refused and the next identical read to be served.

// File: rtl/sram_gate_pkg.sv
package sram_gate_pkg;

  // Which configuration register an access selects.
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_VEC,
    SEL_LOCK,
    SEL_CTL,
    SEL_STAT,
    SEL_CLR
  } cfgSelT;

  // Strobes from the control module to the datapath.
  typedef struct packed {
    cfgSelT sel;
    logic   wrEn;
    logic   illegal;
  } cfgStrobeT;

  localparam int STAT_W = 2;

endpackage

// File: rtl/gate_ctrl.sv
module gate_ctrl
  import sram_gate_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int VIDX_W  = 3
) (
  input  logic              cfgValid,
  input  logic              cfgWrite,
  input  logic              cfgSecure,
  input  logic [VIDX_W:0]   cfgAddr,
  input  logic [NUM_VEC-1:0] lockBits,
  output cfgStrobeT         strobe
);

  logic [VIDX_W-1:0] wordIdx;
  assign wordIdx = cfgAddr[VIDX_W-1:0];

  always_comb begin
    strobe.sel     = SEL_NONE;
    strobe.wrEn    = 1'b0;
    strobe.illegal = 1'b0;
    if (cfgValid) begin
      if (!cfgSecure) begin
        strobe.illegal = 1'b1;
      end else if (!cfgAddr[VIDX_W]) begin
        strobe.sel  = SEL_VEC;
        strobe.wrEn = cfgWrite & ~lockBits[wordIdx];
      end else if (cfgAddr[VIDX_W-1:2] == '0) begin
        strobe.wrEn = cfgWrite;
        unique case (cfgAddr[1:0])
          2'd0:    strobe.sel = SEL_LOCK;
          2'd1:    strobe.sel = SEL_CTL;
          2'd2:    strobe.sel = SEL_STAT;
          default: strobe.sel = SEL_CLR;
        endcase
      end
    end
  end

endmodule

// File: rtl/gate_datapath.sv
module gate_datapath
  import sram_gate_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int VEC_W   = 32,
  parameter int NUM_VEC = 8,
  parameter int VIDX_W  = 3,
  parameter int BIDX_W  = 5
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  cfgStrobeT                strobe,
  input  logic [VIDX_W-1:0]        cfgIdx,
  input  logic [VEC_W-1:0]         cfgWdata,
  output logic [VEC_W-1:0]         cfgRdata,
  output logic [NUM_VEC-1:0]       lockBits,
  output logic [STAT_W-1:0]        statBits,
  output logic                     ctlEn,
  input  logic                     reqValid,
  input  logic                     reqSecure,
  input  logic [VIDX_W+BIDX_W-1:0] blkAddr,
  output logic                     fwdOk,
  input  logic [DATA_W-1:0]        memRdata,
  output logic                     rspValid,
  output logic                     rspErr,
  output logic [DATA_W-1:0]        rspRdata
);

  logic [VEC_W-1:0]  vecQ [NUM_VEC];
  logic [NUM_VEC-1:0] lockQ;
  logic              ctlQ;
  logic [STAT_W-1:0] statQ;
  logic              rspValidQ;
  logic              blockedQ;

  logic [VIDX_W-1:0] vIdx;
  logic [BIDX_W-1:0] bIdx;
  logic              nsBlock;
  logic              allow;
  logic              viol;
  logic [STAT_W-1:0] setMask;
  logic [STAT_W-1:0] clrMask;

  // Attribute words, one register per group of blocks.
  for (genvar g = 0; g < NUM_VEC; g++) begin : g_vec
    always_ff @(posedge clk) begin
      if (!rstN) begin
        vecQ[g] <= '0;
      end else if (strobe.sel == SEL_VEC && strobe.wrEn && cfgIdx == VIDX_W'(g)) begin
        vecQ[g] <= cfgWdata;
      end
    end
  end

  // Lock word, sticky ones.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockQ <= '0;
    end else if (strobe.sel == SEL_LOCK && strobe.wrEn) begin
      lockQ <= lockQ | cfgWdata[NUM_VEC-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlQ <= 1'b0;
    end else if (strobe.sel == SEL_CTL && strobe.wrEn) begin
      ctlQ <= cfgWdata[0];
    end
  end

  // Block lookup and gating decision.
  assign vIdx    = blkAddr[BIDX_W +: VIDX_W];
  assign bIdx    = blkAddr[BIDX_W-1:0];
  assign nsBlock = vecQ[vIdx][bIdx];
  assign allow   = reqSecure | nsBlock;
  assign fwdOk   = reqValid & allow;
  assign viol    = reqValid & ~allow;

  // Status: clear first, then new events win.
  assign setMask = {strobe.illegal, viol};
  assign clrMask = (strobe.sel == SEL_CLR && strobe.wrEn) ? cfgWdata[STAT_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statQ <= '0;
    end else begin
      statQ <= (statQ & ~clrMask) | setMask;
    end
  end

  // Response stage.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValidQ <= 1'b0;
      blockedQ  <= 1'b0;
    end else begin
      rspValidQ <= reqValid;
      blockedQ  <= viol;
    end
  end

  assign rspValid = rspValidQ;
  assign rspErr   = blockedQ;
  assign rspRdata = blockedQ ? '0 : memRdata;

  // Configuration read mux.
  always_comb begin
    cfgRdata = '0;
    unique case (strobe.sel)
      SEL_VEC:  cfgRdata = vecQ[cfgIdx];
      SEL_LOCK: cfgRdata = VEC_W'(lockQ);
      SEL_CTL:  cfgRdata = VEC_W'(ctlQ);
      SEL_STAT: cfgRdata = VEC_W'(statQ);
      default:  cfgRdata = '0;
    endcase
  end

  assign lockBits = lockQ;
  assign statBits = statQ;
  assign ctlEn    = ctlQ;

endmodule

// File: rtl/sram_sec_gate.sv
module sram_sec_gate
  import sram_gate_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int BLOCK_BITS = 8,
  parameter int VEC_W      = 32,
  localparam int NUM_BLOCKS = 2 ** (ADDR_W - BLOCK_BITS),
  localparam int NUM_VEC    = NUM_BLOCKS / VEC_W,
  localparam int VIDX_W     = $clog2(NUM_VEC),
  localparam int BIDX_W     = $clog2(VEC_W),
  localparam int CFG_AW     = VIDX_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqSecure,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic              rspErr,
  output logic [DATA_W-1:0] rspRdata,
  output logic              memValid,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              cfgValid,
  input  logic              cfgWrite,
  input  logic              cfgSecure,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [VEC_W-1:0]  cfgWdata,
  output logic [VEC_W-1:0]  cfgRdata,
  output logic              cfgErr,
  output logic              irq
);

  cfgStrobeT          strobe;
  logic [NUM_VEC-1:0] lockBits;
  logic [STAT_W-1:0]  statBits;
  logic               ctlEn;

  gate_ctrl #(
    .NUM_VEC (NUM_VEC),
    .VIDX_W  (VIDX_W)
  ) u_ctrl (
    .cfgValid  (cfgValid),
    .cfgWrite  (cfgWrite),
    .cfgSecure (cfgSecure),
    .cfgAddr   (cfgAddr),
    .lockBits  (lockBits),
    .strobe    (strobe)
  );

  gate_datapath #(
    .DATA_W  (DATA_W),
    .VEC_W   (VEC_W),
    .NUM_VEC (NUM_VEC),
    .VIDX_W  (VIDX_W),
    .BIDX_W  (BIDX_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cfgIdx    (cfgAddr[VIDX_W-1:0]),
    .cfgWdata  (cfgWdata),
    .cfgRdata  (cfgRdata),
    .lockBits  (lockBits),
    .statBits  (statBits),
    .ctlEn     (ctlEn),
    .reqValid  (reqValid),
    .reqSecure (reqSecure),
    .blkAddr   (reqAddr[ADDR_W-1:BLOCK_BITS]),
    .fwdOk     (memValid),
    .memRdata  (memRdata),
    .rspValid  (rspValid),
    .rspErr    (rspErr),
    .rspRdata  (rspRdata)
  );

  assign memWrite = reqWrite;
  assign memAddr  = reqAddr;
  assign memWdata = reqWdata;
  assign cfgErr   = strobe.illegal;
  assign irq      = ctlEn & (|statBits);

endmodule

// File: rtl/gate_checker.sv
module gate_checker #(
  parameter int DATA_W  = 32,
  parameter int VEC_W   = 32,
  parameter int NUM_VEC = 8,
  parameter int STAT_W  = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic               reqSecure,
  input logic               memValid,
  input logic               rspValid,
  input logic               rspErr,
  input logic [DATA_W-1:0]  rspRdata,
  input logic               cfgValid,
  input logic               cfgSecure,
  input logic               cfgErr,
  input logic [VEC_W-1:0]   cfgRdata,
  input logic [NUM_VEC-1:0] lockBits,
  input logic [STAT_W-1:0]  statBits
);

  p_fwd_origin_r3: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> reqValid);

  p_blocked_err_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !memValid) |=> (rspValid && rspErr));

  p_err_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> (rspRdata == '0));

  p_secure_pass_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSecure) |-> memValid);

  p_ok_noerr_r4: assert property (@(posedge clk) disable iff (!rstN)
    memValid |=> (rspValid && !rspErr));

  p_lock_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((lockBits & $past(lockBits)) == $past(lockBits)));

  p_cfg_refused_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cfgValid && !cfgSecure) |-> (cfgErr && cfgRdata == '0));

  p_cfg_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cfgValid && !cfgSecure) |=> statBits[1]);

  p_viol_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !memValid) |=> statBits[0]);

endmodule

bind sram_sec_gate gate_checker #(
  .DATA_W  (DATA_W),
  .VEC_W   (VEC_W),
  .NUM_VEC (NUM_VEC),
  .STAT_W  (sram_gate_pkg::STAT_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqSecure (reqSecure),
  .memValid  (memValid),
  .rspValid  (rspValid),
  .rspErr    (rspErr),
  .rspRdata  (rspRdata),
  .cfgValid  (cfgValid),
  .cfgSecure (cfgSecure),
  .cfgErr    (cfgErr),
  .cfgRdata  (cfgRdata),
  .lockBits  (lockBits),
  .statBits  (statBits)
);

// File: tb/sim_sram_sec_gate.sv
module sim_sram_sec_gate;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqSecure = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        rspValid, rspErr;
  logic [31:0] rspRdata;
  logic        memValid, memWrite;
  logic [15:0] memAddr;
  logic [31:0] memWdata;
  logic [31:0] memRdata = '0;
  logic        cfgValid = 1'b0, cfgWrite = 1'b0, cfgSecure = 1'b0;
  logic [3:0]  cfgAddr = '0;
  logic [31:0] cfgWdata = '0;
  logic [31:0] cfgRdata;
  logic        cfgErr, irq;

  always #5 clk = ~clk;

  sram_sec_gate u0 (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqSecure(reqSecure),
    .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspErr(rspErr), .rspRdata(rspRdata),
    .memValid(memValid), .memWrite(memWrite), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata),
    .cfgValid(cfgValid), .cfgWrite(cfgWrite), .cfgSecure(cfgSecure),
    .cfgAddr(cfgAddr), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .cfgErr(cfgErr), .irq(irq)
  );

  // Memory model behind the gate.
  logic [31:0] memArr [0:1023];
  always @(posedge clk) begin
    if (memValid) begin
      if (memWrite) memArr[memAddr[11:2]] <= memWdata;
      else          memRdata <= memArr[memAddr[11:2]];
    end
  end

  // Bench-side expectations.
  logic [31:0] shadow [0:1023];
  logic [31:0] expVec [0:7];
  logic [7:0]  expLock = '0;
  logic        expCtl = 1'b0;
  logic [1:0]  expStat = '0;
  logic [33:0] expQ [$];   // {isRead, err, data}
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit isAllowed(input bit sec, input logic [15:0] a);
    return sec || expVec[a[15:13]][a[12:8]];
  endfunction

  task automatic pushXfer(input bit wr, input logic [15:0] a, input logic [31:0] d,
                          input bit allowed);
    expQ.push_back({!wr, !allowed, (allowed && !wr) ? shadow[a[11:2]] : 32'h0});
    if (allowed && wr) shadow[a[11:2]] = d;
    if (!allowed) expStat[0] = 1'b1;
  endtask

  task automatic cfgModel(input bit sec, input logic [3:0] a, input logic [31:0] d);
    if (!sec) expStat[1] = 1'b1;
    else if (!a[3]) begin
      if (!expLock[a[2:0]]) expVec[a[2:0]] = d;
    end else if (a == 4'd8) expLock = expLock | d[7:0];
    else if (a == 4'd9) expCtl = d[0];
    else if (a == 4'd11) expStat = expStat & ~d[1:0];
  endtask

  task automatic xfer(input bit wr, input bit sec, input logic [15:0] a, input logic [31:0] d);
    bit ok;
    ok = isAllowed(sec, a);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqSecure = sec; reqAddr = a; reqWdata = d;
    pushXfer(wr, a, d, ok);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic cfgWr(input bit sec, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgValid = 1'b1; cfgWrite = 1'b1; cfgSecure = sec; cfgAddr = a; cfgWdata = d;
    cfgModel(sec, a, d);
    @(negedge clk);
    cfgValid = 1'b0; cfgWrite = 1'b0;
  endtask

  task automatic cfgRd(input bit sec, input logic [3:0] a, input logic [31:0] exp,
                       input string req);
    @(negedge clk);
    cfgValid = 1'b1; cfgWrite = 1'b0; cfgSecure = sec; cfgAddr = a;
    #2;
    chk(req, cfgRdata, exp);
    chk({req, " err"}, {31'h0, cfgErr}, {31'h0, !sec});
    if (!sec) expStat[1] = 1'b1;
    @(negedge clk);
    cfgValid = 1'b0;
  endtask

  // Config write and transfer in the same cycle.
  task automatic collide(input logic [3:0] ca, input logic [31:0] cd, input bit wr,
                         input bit sec, input logic [15:0] a, input logic [31:0] d);
    bit ok;
    ok = isAllowed(sec, a);
    @(negedge clk);
    cfgValid = 1'b1; cfgWrite = 1'b1; cfgSecure = 1'b1; cfgAddr = ca; cfgWdata = cd;
    reqValid = 1'b1; reqWrite = wr; reqSecure = sec; reqAddr = a; reqWdata = d;
    cfgModel(1'b1, ca, cd);
    pushXfer(wr, a, d, ok);
    @(negedge clk);
    cfgValid = 1'b0; cfgWrite = 1'b0; reqValid = 1'b0;
  endtask

  task automatic chkIrq(input string req);
    @(negedge clk);
    #2;
    chk(req, {31'h0, irq}, {31'h0, expCtl && (expStat != 2'b00)});
  endtask

  // Scoreboard monitor.
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (expQ.size() == 0) begin
        checks++; failures++;
        $display("FAIL R3/R4 unexpected response actual=%h expected=none", rspRdata);
      end else begin
        logic [33:0] it;
        it = expQ.pop_front();
        chk(it[33] ? "R3/R4 read response err" : "R3/R4 write response err",
            {31'h0, rspErr}, {31'h0, it[32]});
        if (it[33]) chk(it[32] ? "R3 blocked read data" : "R4 read data", rspRdata, it[31:0]);
      end
    end
  end

  task automatic finishRun;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin memArr[i] = '0; shadow[i] = '0; end
    for (int i = 0; i < 8; i++) expVec[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    for (int i = 0; i < 8; i++) cfgRd(1'b1, 4'(i), 32'h0, "R1 attribute word");
    cfgRd(1'b1, 4'd8, 32'h0, "R1 lock word");
    cfgRd(1'b1, 4'd9, 32'h0, "R1 control word");
    cfgRd(1'b1, 4'd10, 32'h0, "R1 status word");
    chkIrq("R1 irq");

    // R3: non-secure to secure block
    xfer(1'b0, 1'b0, 16'h0100, 32'h0);
    xfer(1'b1, 1'b0, 16'h0104, 32'hAAAA_5555);
    cfgRd(1'b1, 4'd10, {30'h0, expStat}, "R8 status after block");
    chkIrq("R8 irq disabled");

    // R4: secure traffic passes
    xfer(1'b1, 1'b1, 16'h0104, 32'h1234_5678);
    xfer(1'b0, 1'b1, 16'h0104, 32'h0);
    xfer(1'b0, 1'b1, 16'h0100, 32'h0);

    // R2: block lookup (addr 0x4500 -> word 2 bit 5)
    cfgWr(1'b1, 4'd2, 32'h0000_0020);
    xfer(1'b1, 1'b0, 16'h4500, 32'h0000_5555);
    xfer(1'b0, 1'b0, 16'h4500, 32'h0);
    xfer(1'b0, 1'b0, 16'h4400, 32'h0);
    xfer(1'b0, 1'b0, 16'h6500, 32'h0);
    xfer(1'b0, 1'b0, 16'h45FC, 32'h0);

    // R7: non-secure configuration access
    cfgWr(1'b0, 4'd2, 32'h0);
    cfgRd(1'b1, 4'd2, 32'h0000_0020, "R7 word unchanged after ns write");
    cfgRd(1'b0, 4'd2, 32'h0, "R7 ns read");
    cfgRd(1'b1, 4'd10, {30'h0, expStat}, "R7 status bit1");

    // R5/R6: locking
    cfgWr(1'b1, 4'd8, 32'h0000_0004);
    cfgWr(1'b1, 4'd2, 32'hFFFF_FFFF);
    cfgRd(1'b1, 4'd2, 32'h0000_0020, "R6 locked word ignored");
    cfgWr(1'b1, 4'd8, 32'h0);
    cfgRd(1'b1, 4'd8, 32'h0000_0004, "R5 lock not clearable");
    cfgWr(1'b1, 4'd8, 32'h0000_0001);
    cfgRd(1'b1, 4'd8, 32'h0000_0005, "R5 lock ORs");
    cfgWr(1'b1, 4'd1, 32'h0000_00F0);
    cfgRd(1'b1, 4'd1, 32'h0000_00F0, "R6 unlocked word written");

    // R8: interrupt
    cfgWr(1'b1, 4'd11, 32'h3);
    cfgRd(1'b1, 4'd10, 32'h0, "R9 status cleared");
    cfgWr(1'b1, 4'd9, 32'h1);
    chkIrq("R8 irq low with empty status");
    xfer(1'b0, 1'b0, 16'h0200, 32'h0);
    chkIrq("R8 irq on violation");

    // R9: clear collides with new violation
    collide(4'd11, 32'h1, 1'b0, 1'b0, 16'h0300, 32'h0);
    cfgRd(1'b1, 4'd10, 32'h1, "R9 set wins over clear");
    chkIrq("R9 irq held");
    cfgWr(1'b1, 4'd11, 32'h1);
    cfgRd(1'b1, 4'd10, 32'h0, "R9 lone clear");
    chkIrq("R9 irq drops");

    // R10: attribute write collides with a transfer to that block
    collide(4'd1, 32'h0000_00F8, 1'b0, 1'b0, 16'h2300, 32'h0);
    xfer(1'b0, 1'b0, 16'h2300, 32'h0);
    cfgRd(1'b1, 4'd10, {30'h0, expStat}, "R10 status after old-attribute block");

    repeat (4) @(negedge clk);
    chk("R3/R4 all responses seen", expQ.size(), 32'h0);
    finishRun();
  end

endmodule